// File: doc/BRIEF.md
# Composite Video Frame Sampling Controller

This controller takes one low-resolution still picture from a composite video stream and stores it in an external SRAM. A sync separator supplies active-low vertical and composite sync pulses, already synchronous to the 10 MHz system clock. The controller counts line periods after the vertical sync to find the first picture line. It then times samples inside each chosen line in clock cycles, counted from that line's composite sync edge.

The picture grid is 14 columns by 10 rows. A row is taken from every 24th line, starting with the first picture line. Within a chosen line the samples are spaced 37 and 38 cycles apart in turn. Each sample is stored with a two-cycle write. In the first cycle the converter is strobed and drives the shared data bus. In the second cycle the write enable pulses while the address stays fixed. Software arms a capture with `enable` and watches `done`.

Top module: `vid_grab_ctrl`

## Requirements
- R1: While reset is high and after it is released, all strobes (`ad_clk`, `ad_oe`, `sram_we`, `row_inc`) are low, `done` is low and `sram_addr` is 0.
- R2: A capture is armed only by a falling edge of `vsync_n` seen while `enable` is high and `done` is low. The first captured line is the one started by the 17th falling edge of `csync_n` after that edge. A `csync_n` fall seen in the same cycle as the `vsync_n` fall is not counted.
- R3: In a captured line, the first column's sample strobe `ad_clk` is high exactly 95 cycles after the cycle in which the low `csync_n` is first sampled.
- R4: Each later column's strobe follows the previous one by 37 cycles after an even column (0, 2, …) and by 38 cycles after an odd column. Exactly 14 samples are taken per captured line.
- R5: Each store lasts two cycles. `ad_oe` is high in both cycles, `ad_clk` only in the first and `sram_we` only in the second, and `sram_addr` is the same in both cycles.
- R6: Rows are taken from the first captured line and then from every 24th line after it, 10 rows in all. No strobe appears on any other line, before arming or after completion.
- R7: The address written for row r, column c is r*14 + c, starting at 0 for every frame. After location 139 is written, `sram_addr` stays at 139.
- R8: `row_inc` is a one-cycle pulse in the cycle after the write-enable cycle of column 13. It appears exactly 10 times per frame.
- R9: `done` rises in the cycle after the last `row_inc` and stays high while `enable` stays high. No write and no re-arming happen while `done` is high.
- R10: When `enable` is low, the next cycle has no strobe and `done` is cleared. A capture in progress is abandoned.
- R11: `sram_wdata` equals `ad_data` while `ad_oe` is high and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 10 MHz system clock |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Arms capture; low abandons it and clears done |
| vsync_n | input | 1 | Vertical sync, active low, synchronous |
| csync_n | input | 1 | Composite sync, active low, synchronous |
| ad_data | input | DW (8) | Sample from the A/D converter |
| ad_clk | output | 1 | Sample strobe to the converter |
| ad_oe | output | 1 | Converter drives the shared data bus |
| sram_addr | output | $clog2(ROWS*COLS) (8) | SRAM word address |
| sram_wdata | output | DW (8) | Data toward SRAM, gated by ad_oe |
| sram_we | output | 1 | SRAM write enable, active high |
| row_inc | output | 1 | One-cycle pulse at the end of each stored row |
| done | output | 1 | All rows of the frame stored |

## Verification
The vertical sync fall and a composite sync fall can land in the same cycle. The controller must then arm and ignore that line edge, so the count of 17 starts with the next edge. The bench provokes this by restarting its sync generator with the vertical edge placed at the start of a line. It judges the result by the first sample strobe, which must come exactly 17 line periods plus 95 cycles after the shared edge; a strobe one line early is also flagged as a sample on a line that must stay silent. A cycle-by-cycle reference model checks every strobe, address and row pulse over a full frame at the default sizes.

// File: rtl/vid_grab_ctrl.sv
`timescale 1ns/1ps
module vid_grab_ctrl #(
  parameter int DW          = 8,
  parameter int COLS        = 14,
  parameter int ROWS        = 10,
  parameter int FRONT_LINES = 17,
  parameter int LINE_STRIDE = 24,
  parameter int START_CYC   = 95,
  parameter int STEP_EVEN   = 37,
  parameter int STEP_ODD    = 38
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          enable,
  input  logic                          vsync_n,
  input  logic                          csync_n,
  input  logic [DW-1:0]                 ad_data,
  output logic                          ad_clk,
  output logic                          ad_oe,
  output logic [$clog2(ROWS*COLS)-1:0]  sram_addr,
  output logic [DW-1:0]                 sram_wdata,
  output logic                          sram_we,
  output logic                          row_inc,
  output logic                          done
);
  localparam int CELLS = ROWS * COLS;
  localparam int AW = $clog2(CELLS);
  localparam int HW = $clog2(FRONT_LINES + 1);
  localparam int SW = $clog2(LINE_STRIDE + 1);
  localparam int CW = $clog2(COLS + 1);
  localparam int RW = $clog2(ROWS + 1);
  localparam int TW = $clog2(START_CYC + STEP_ODD + 1);
  localparam logic [AW-1:0] A_END = AW'(CELLS - 1);
  localparam logic [HW-1:0] H_END = HW'(FRONT_LINES - 1);
  localparam logic [SW-1:0] S_END = SW'(LINE_STRIDE - 1);
  localparam logic [CW-1:0] C_END = CW'(COLS - 1);
  localparam logic [RW-1:0] R_END = RW'(ROWS - 1);
  localparam logic [TW-1:0] T_START = TW'(START_CYC - 1);
  localparam logic [TW-1:0] T_EVEN = TW'(STEP_EVEN - 3);
  localparam logic [TW-1:0] T_ODD = TW'(STEP_ODD - 3);

  typedef enum logic [3:0] {
    ST_IDLE, ST_SKIP, ST_DELAY, ST_WR0, ST_WR1, ST_GAP, ST_ROWEND, ST_WAIT, ST_DONE
  } state_t;

  state_t          state;
  logic            vs_q, cs_q;
  logic [TW-1:0]   tmr;
  logic [HW-1:0]   hcnt;
  logic [SW-1:0]   skip;
  logic [CW-1:0]   col;
  logic [RW-1:0]   row;
  logic [AW-1:0]   addr;
  logic            fin;

  wire vs_fall = vs_q & ~vsync_n;
  wire cs_fall = cs_q & ~csync_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      vs_q <= 1'b1;
      cs_q <= 1'b1;
    end else begin
      vs_q <= vsync_n;
      cs_q <= csync_n;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      tmr   <= '0;
      hcnt  <= '0;
      skip  <= '0;
      col   <= '0;
      row   <= '0;
      addr  <= '0;
      fin   <= 1'b0;
    end else if (!enable) begin
      state <= ST_IDLE;
      fin   <= 1'b0;
    end else if (vs_fall && state != ST_DONE) begin
      state <= ST_SKIP;
      hcnt  <= '0;
    end else begin
      case (state)
        ST_SKIP: if (cs_fall) begin
          if (hcnt == H_END) begin
            state <= ST_DELAY;
            tmr   <= T_START;
            row   <= '0;
            col   <= '0;
            addr  <= '0;
            skip  <= '0;
          end else begin
            hcnt <= hcnt + 1'b1;
          end
        end
        ST_DELAY, ST_GAP: begin
          if (tmr == '0) state <= ST_WR0;
          else tmr <= tmr - 1'b1;
        end
        ST_WR0: state <= ST_WR1;
        ST_WR1: begin
          if (addr != A_END) addr <= addr + 1'b1;
          if (col == C_END) begin
            col   <= '0;
            state <= ST_ROWEND;
          end else begin
            col   <= col + 1'b1;
            tmr   <= col[0] ? T_ODD : T_EVEN;
            state <= ST_GAP;
          end
        end
        ST_ROWEND: begin
          if (row == R_END) begin
            state <= ST_DONE;
            fin   <= 1'b1;
          end else begin
            row   <= row + 1'b1;
            skip  <= '0;
            state <= ST_WAIT;
          end
        end
        ST_WAIT: if (cs_fall) begin
          if (skip == S_END) begin
            skip  <= '0;
            tmr   <= T_START;
            state <= ST_DELAY;
          end else begin
            skip <= skip + 1'b1;
          end
        end
        default: state <= state;
      endcase
    end
  end

  assign ad_clk     = (state == ST_WR0);
  assign sram_we    = (state == ST_WR1);
  assign ad_oe      = ad_clk | sram_we;
  assign row_inc    = (state == ST_ROWEND);
  assign done       = fin;
  assign sram_addr  = addr;
  assign sram_wdata = ad_oe ? ad_data : '0;

  assert_we_after_strobe_R5: assert property (@(posedge clk) disable iff (rst)
    sram_we |-> ($past(ad_clk) && $stable(sram_addr)));

  assert_addr_step_R7: assert property (@(posedge clk) disable iff (rst)
    (sram_we && enable && !vs_fall && sram_addr != A_END) |=> (sram_addr == $past(sram_addr) + 1'b1));

  assert_addr_cap_R7: assert property (@(posedge clk) disable iff (rst)
    sram_addr <= A_END);

  assert_rowinc_after_write_R8: assert property (@(posedge clk) disable iff (rst)
    row_inc |-> $past(sram_we));

  assert_done_after_rowinc_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $past(row_inc));

  assert_quiet_when_done_R9: assert property (@(posedge clk) disable iff (rst)
    done |-> !ad_oe);

  assert_idle_when_disabled_R10: assert property (@(posedge clk) disable iff (rst)
    $past(!enable) |-> (!ad_oe && !row_inc && !done));
endmodule

// File: tb/tb_vid_grab_ctrl.sv
`timescale 1ns/1ps
module tb_vid_grab_ctrl;
  localparam int LINE = 635, SYNC_W = 47, NCOL = 14, NROW = 10;
  localparam int FIRST = 17, STRIDE = 24, LASTA = 139;
  localparam int OFF [NCOL] = '{95, 132, 170, 207, 245, 282, 320,
                                357, 395, 432, 470, 507, 545, 582};

  logic clk = 1'b0, rst = 1'b1, enable = 1'b0, vsync_n = 1'b1, csync_n = 1'b1;
  logic [7:0] ad_data = 8'h00;
  logic ad_clk, ad_oe, sram_we, row_inc, done;
  logic [7:0] sram_addr, sram_wdata;

  int cyc = 0, checks = 0, fails = 0;
  int gen_req = 0, gen_seen = 0, line_pos = 0, line_cnt = 0, vs_pos = 300;
  bit armed = 0, cap = 0, m_done = 0, p_cs = 1, p_vs = 1;
  int fall_num = 0, cap_row = 0, fall_ref = 0, vs_ref = 0;
  int n_we = 0, n_ri = 0, line_we = 0, first_clk = -1;

  vid_grab_ctrl dut (
    .clk(clk), .rst(rst), .enable(enable), .vsync_n(vsync_n), .csync_n(csync_n),
    .ad_data(ad_data), .ad_clk(ad_clk), .ad_oe(ad_oe), .sram_addr(sram_addr),
    .sram_wdata(sram_wdata), .sram_we(sram_we), .row_inc(row_inc), .done(done)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", req, cyc, act, exp);
    end
  endtask

  always @(negedge clk) begin : mon
    bit e_clk, e_oe, e_we, e_ri, vf, cf;
    int e_addr, rel, nxt;
    string tg;
    if (!rst) begin
      e_clk = 0; e_oe = 0; e_we = 0; e_ri = 0; e_addr = -1;
      if (cap) begin
        rel = cyc - fall_ref;
        for (int c = 0; c < NCOL; c++) begin
          if (rel == OFF[c]) begin e_clk = 1; e_oe = 1; e_addr = cap_row * NCOL + c; end
          if (rel == OFF[c] + 1) begin e_oe = 1; e_we = 1; e_addr = cap_row * NCOL + c; end
        end
        if (rel == OFF[NCOL-1] + 2) e_ri = 1;
      end
      if (e_clk || ad_clk) begin
        tg = !e_clk ? "R6" : ((e_addr % NCOL) == 0 ? "R3" : "R4");
        chk(ad_clk == e_clk, tg, ad_clk, e_clk);
      end
      if (e_oe || ad_oe) chk(ad_oe == e_oe, e_oe ? "R5" : "R6", ad_oe, e_oe);
      if (e_we || sram_we) chk(sram_we == e_we, "R5", sram_we, e_we);
      if (e_oe) chk(sram_addr == e_addr, "R7", sram_addr, e_addr);
      if (e_ri || row_inc) chk(row_inc == e_ri, "R8", row_inc, e_ri);
      if (m_done || done) chk(done == m_done, "R9", done, m_done);
      if (ad_oe || sram_wdata != 0)
        chk(sram_wdata == (ad_oe ? ad_data : 8'h00), "R11", sram_wdata, ad_oe ? ad_data : 0);
      if (ad_clk && first_clk < 0) first_clk = cyc;
      if (sram_we) begin n_we++; line_we++; end
      if (row_inc) begin
        n_ri++;
        chk(line_we == NCOL, "R4", line_we, NCOL);
        line_we = 0;
      end
    end
    p_cs = csync_n;
    p_vs = vsync_n;
    if (gen_seen != gen_req) begin
      gen_seen = gen_req; line_pos = LINE - 100; line_cnt = -1; line_we = 0; first_clk = -1;
    end else if (gen_seen > 0) begin
      line_pos++;
      if (line_pos == LINE) begin line_pos = 0; line_cnt++; end
    end
    if (gen_seen > 0) begin
      csync_n = (line_pos >= SYNC_W);
      if (line_cnt == 0 && line_pos == vs_pos) vsync_n = 1'b0;
      if (line_cnt == 3 && line_pos == vs_pos) vsync_n = 1'b1;
      ad_data = 8'(cyc * 7 + 3);
    end
    if (!rst) begin
      vf = p_vs && !vsync_n;
      cf = p_cs && !csync_n;
      nxt = cyc + 1;
      if (!enable) begin
        armed = 0; cap = 0; m_done = 0;
      end else if (vf && !m_done) begin
        armed = 1; fall_num = 0; cap = 0; vs_ref = nxt;
      end else begin
        if (armed && cf) begin
          fall_num++;
          if (fall_num >= FIRST && (fall_num - FIRST) % STRIDE == 0 &&
              (fall_num - FIRST) / STRIDE < NROW) begin
            cap = 1; cap_row = (fall_num - FIRST) / STRIDE; fall_ref = nxt;
          end else begin
            cap = 0;
          end
        end
        if (cap && cap_row == NROW - 1 && nxt - fall_ref == OFF[NCOL-1] + 3) begin
          m_done = 1; cap = 0; armed = 0;
        end
      end
    end
  end

  initial begin : wd
    repeat (190000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired at cycle %0d: actual=1 expected=0", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : main
    int we0, ri0;
    repeat (4) @(posedge clk);
    chk(!ad_oe && !sram_we && !row_inc && !done, "R1", {ad_oe, sram_we, row_inc, done}, 0);
    #1 rst = 1'b0;
    @(negedge clk);
    chk(!ad_clk && !ad_oe && !sram_we && !row_inc, "R1", {ad_clk, ad_oe, sram_we, row_inc}, 0);
    chk(!done, "R1", done, 0);
    chk(sram_addr == 0, "R1", sram_addr, 0);

    @(posedge clk); #1 enable = 1'b1; gen_req = 1;
    while (!done) @(posedge clk);
    #1;
    chk(n_we == NROW * NCOL, "R6", n_we, NROW * NCOL);
    chk(n_ri == NROW, "R8", n_ri, NROW);
    chk(sram_addr == LASTA, "R7", sram_addr, LASTA);
    we0 = n_we;
    repeat (2 * LINE) @(posedge clk);
    #1;
    chk(done == 1'b1, "R9", done, 1);
    chk(n_we == we0, "R9", n_we, we0);
    chk(sram_addr == LASTA, "R7", sram_addr, LASTA);
    enable = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    chk(done == 1'b0, "R10", done, 0);

    vs_pos = 0;
    enable = 1'b1;
    gen_req = 2;
    repeat (100 + FIRST * LINE + 250) @(posedge clk);
    #1;
    chk(first_clk - vs_ref == FIRST * LINE + OFF[0], "R2", first_clk - vs_ref, FIRST * LINE + OFF[0]);
    chk(n_we > we0, "R2", n_we - we0, 1);
    enable = 1'b0;
    we0 = n_we; ri0 = n_ri;
    repeat (2 * LINE) @(posedge clk);
    #1;
    chk(n_we == we0, "R10", n_we, we0);
    chk(n_ri == ri0 && !done, "R10", n_ri - ri0, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule